// File: doc/BRIEF.md
# Configuration Item Port

This block gives a host sequential, byte-granular access to a small set of read-only configuration items. The host writes a 16-bit key into a selector register to choose an item. Each read of the data register then returns the next bytes of that item and moves the item's read pointer forward. The items live in a parameterised internal store whose contents are computed, not loaded. Two items are fixed: a four-byte ASCII signature and a feature word.

The host side is a plain register bus. It carries an address, a write strobe, a read strobe, a two-bit access size and a 16-bit write-data field. Reads are answered through a 64-bit data bus qualified by a one-cycle valid pulse. A small state machine sequences each read through three states:

- ST_IDLE accepts strobes.
- ST_LOOKUP computes the masked byte lanes and the new offset.
- ST_REPLY presents the result.

The transitions are:

- ST_IDLE→ST_LOOKUP on a read strobe that is not paired with a write.
- ST_LOOKUP→ST_REPLY unconditionally.
- ST_REPLY→ST_IDLE unconditionally.

Selector and data writes are handled inside ST_IDLE and do not leave it.

Top module: `cfg_item_port`

## Requirements
- R1: After reset the selected key is 0x0000 with read offset 0, `bus_busy` and `bus_rvalid` are 0, and `bus_rdata` is zero.
- R2: A write (strobe sampled in ST_IDLE) to the selector address loads `bus_wdata` as the current key and sets the read offset to 0. Re-selecting an item restarts it from its first byte.
- R3: A data read of size code s (0,1,2,3 → N = 1,2,4,8 bytes) returns the next N bytes of the current item. The byte at the lowest item offset is in bits 7:0, and each following byte sits in the next higher byte lane. Lanes at or above N read zero. The offset then advances by N.
- R4: Key 0x0000 holds the signature given by parameter SIGNATURE in string order (default "CFGS", so lane 0 reads 0x43). Its length is 4.
- R5: Key 0x0001 is a 4-byte little-endian feature word. Bit 0 is always 1, and bit 1 equals parameter HAS_DMA. With the default of 1, the word reads 0x00000003.
- R6: Key bit 14 is ignored for lookup, so key k|0x4000 reads exactly like key k.
- R7: Keys with bit 15 set address a separate architecture bank. Item j (key 0x8000+j, j < NUM_ARCH) has length 6+2j. Its byte at offset p is ((19j+7p) mod 256) XOR 0xA0. In the generic bank, item i (key 0x0020+i, i < NUM_GEN) has length 3+5i, and its byte at offset p is (37i+11p+5) mod 256.
- R8: Bytes at or past the item length read 0x00, and the offset saturates at the item length.
- R9: A key that names no item behaves as a zero-length item, so every read of it returns zero.
- R10: Writes to the data address are ignored. They change neither the key nor the offset.
- R11: With PORT_MAPPED=0, data is at address 0 and the selector at address 8. With PORT_MAPPED=1, the selector is at 0 and data at 1. A read of any non-data address returns zero with the usual timing and does not move the offset.
- R12: A read strobe sampled at edge k produces `bus_rvalid` high for exactly the cycle after edge k+1. `bus_busy` is high from edge k to edge k+2. Strobes sampled while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (ignored when bus_wr is also high) |
| bus_size | input | 2 | Access size code: 0=1, 1=2, 2=4, 3=8 bytes |
| bus_wdata | input | 16 | Write data (selector key) |
| bus_rdata | output | 64 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | One-cycle read response valid |
| bus_busy | output | 1 | A read is in progress; strobes are ignored |

## Verification
The checker watches every cycle for several properties:

- A selector write loads the key and clears the offset.
- Data writes and strobes issued while busy leave the key unchanged.
- The offset never exceeds the current item's length.
- Reads of non-data addresses answer zero.
- Every read strobe yields a single valid pulse two edges later.

The byte contents cannot be checked cycle by cycle. That covers lane ordering, size masking, the fixed signature and feature items, the bit-14 alias, the two banks and zero fill past the end. Only the bench scenarios, compared against an independent model of item contents and offsets, can show these.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOOKUP = 2'd1,
        ST_REPLY  = 2'd2
    } port_state_e;

    typedef enum logic [2:0] {
        IC_NONE = 3'd0,
        IC_SIG  = 3'd1,
        IC_FEAT = 3'd2,
        IC_GEN  = 3'd3,
        IC_ARCH = 3'd4
    } item_class_e;

    localparam int LANES = 8;

    function automatic logic [3:0] size_bytes(input logic [1:0] code);
        return 4'd1 << code;
    endfunction

endpackage

// File: rtl/cfg_addr_decode.sv
module cfg_addr_decode #(
    parameter int ADDR_W      = 8,
    parameter bit PORT_MAPPED = 1'b0
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              is_sel,
    output logic              is_data
);
    generate
        if (PORT_MAPPED) begin : g_port
            assign is_sel  = (addr == ADDR_W'(0));
            assign is_data = (addr == ADDR_W'(1));
        end else begin : g_mem
            assign is_data = (addr == ADDR_W'(0));
            assign is_sel  = (addr == ADDR_W'(8));
        end
    endgenerate
endmodule

// File: rtl/cfg_item_store.sv
module cfg_item_store
    import cfg_port_pkg::*;
#(
    parameter int          OFF_W     = 12,
    parameter int          NUM_GEN   = 4,
    parameter int          NUM_ARCH  = 2,
    parameter int          DATA_KEY0 = 32,
    parameter bit          HAS_DMA   = 1'b1,
    parameter logic [31:0] SIGNATURE = "CFGS"
) (
    input  logic [15:0]          key,
    input  logic [OFF_W-1:0]     off,
    output logic [OFF_W-1:0]     item_len,
    output logic [8*LANES-1:0]   lanes
);
    localparam logic [13:0] GEN_LO = 14'(DATA_KEY0);
    localparam logic [13:0] GEN_HI = 14'(DATA_KEY0 + NUM_GEN);
    localparam logic [13:0] ARCH_N = 14'(NUM_ARCH);

    logic [15:0]  lookup;
    item_class_e  cls;
    logic [13:0]  idx;

    // bit 14 (legacy write flag) does not take part in lookup
    assign lookup = key & 16'hBFFF;

    always_comb begin
        cls      = IC_NONE;
        idx      = '0;
        item_len = '0;
        if (!lookup[15]) begin
            if (lookup[13:0] == 14'd0) begin
                cls      = IC_SIG;
                item_len = OFF_W'(4);
            end else if (lookup[13:0] == 14'd1) begin
                cls      = IC_FEAT;
                item_len = OFF_W'(4);
            end else if (lookup[13:0] >= GEN_LO && lookup[13:0] < GEN_HI) begin
                cls      = IC_GEN;
                idx      = lookup[13:0] - GEN_LO;
                item_len = OFF_W'(3 + 5 * int'(idx));
            end
        end else if (lookup[13:0] < ARCH_N) begin
            cls      = IC_ARCH;
            idx      = lookup[13:0];
            item_len = OFF_W'(6 + 2 * int'(idx));
        end
    end

    generate
        for (genvar L = 0; L < LANES; L++) begin : g_lane
            logic [OFF_W:0] pos;
            logic [7:0]     b;
            always_comb begin
                pos = {1'b0, off} + (OFF_W+1)'(L);
                b   = 8'h00;
                if (pos < {1'b0, item_len}) begin
                    unique case (cls)
                        IC_SIG:  b = SIGNATURE[8*(3 - int'(pos[1:0])) +: 8];
                        IC_FEAT: b = (pos == '0) ? {6'b0, HAS_DMA, 1'b1} : 8'h00;
                        IC_GEN:  b = 8'(37 * int'(idx) + 11 * int'(pos) + 5);
                        IC_ARCH: b = 8'(19 * int'(idx) + 7 * int'(pos)) ^ 8'hA0;
                        default: b = 8'h00;
                    endcase
                end
            end
            assign lanes[8*L +: 8] = b;
        end
    endgenerate
endmodule

// File: rtl/cfg_port_ctrl.sv
module cfg_port_ctrl
    import cfg_port_pkg::*;
#(
    parameter int OFF_W = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr,
    input  logic                 rd,
    input  logic [1:0]           size,
    input  logic [15:0]          wdata,
    input  logic                 is_sel,
    input  logic                 is_data,
    input  logic [OFF_W-1:0]     item_len,
    input  logic [8*LANES-1:0]   lanes,
    output logic [15:0]          sel_key,
    output logic [OFF_W-1:0]     rd_off,
    output logic [8*LANES-1:0]   rdata,
    output logic                 rvalid,
    output logic                 busy
);
    port_state_e        state_q, state_d;
    logic [3:0]         rd_n;
    logic               rd_to_data;
    logic [8*LANES-1:0] masked;
    logic [OFF_W:0]     sum;
    logic [OFF_W-1:0]   next_off;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (rd && !wr) state_d = ST_LOOKUP;
            ST_LOOKUP: state_d = ST_REPLY;
            ST_REPLY:  state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        rvalid = (state_q == ST_REPLY);
        busy   = (state_q != ST_IDLE);
    end

    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            masked[8*l +: 8] = (l < int'(rd_n)) ? lanes[8*l +: 8] : 8'h00;
        end
        sum      = {1'b0, rd_off} + (OFF_W+1)'(rd_n);
        next_off = (sum > {1'b0, item_len}) ? item_len : sum[OFF_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_key    <= '0;
            rd_off     <= '0;
            rd_n       <= '0;
            rd_to_data <= 1'b0;
            rdata      <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (wr) begin
                        if (is_sel) begin
                            sel_key <= wdata;
                            rd_off  <= '0;
                        end
                    end else if (rd) begin
                        rd_n       <= size_bytes(size);
                        rd_to_data <= is_data;
                    end
                end
                ST_LOOKUP: begin
                    rdata <= rd_to_data ? masked : '0;
                    if (rd_to_data) rd_off <= next_off;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/cfg_item_port.sv
module cfg_item_port
    import cfg_port_pkg::*;
#(
    parameter int          ADDR_W      = 8,
    parameter bit          PORT_MAPPED = 1'b0,
    parameter int          OFF_W       = 12,
    parameter int          NUM_GEN     = 4,
    parameter int          NUM_ARCH    = 2,
    parameter int          DATA_KEY0   = 32,
    parameter bit          HAS_DMA     = 1'b1,
    parameter logic [31:0] SIGNATURE   = "CFGS"
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [1:0]        bus_size,
    input  logic [15:0]       bus_wdata,
    output logic [63:0]       bus_rdata,
    output logic              bus_rvalid,
    output logic              bus_busy
);
    logic               dec_sel, dec_data;
    logic [15:0]        sel_key;
    logic [OFF_W-1:0]   rd_off, item_len;
    logic [8*LANES-1:0] lanes;

    cfg_addr_decode #(.ADDR_W(ADDR_W), .PORT_MAPPED(PORT_MAPPED)) u_dec (
        .addr(bus_addr), .is_sel(dec_sel), .is_data(dec_data)
    );

    cfg_item_store #(
        .OFF_W(OFF_W), .NUM_GEN(NUM_GEN), .NUM_ARCH(NUM_ARCH),
        .DATA_KEY0(DATA_KEY0), .HAS_DMA(HAS_DMA), .SIGNATURE(SIGNATURE)
    ) u_store (
        .key(sel_key), .off(rd_off), .item_len(item_len), .lanes(lanes)
    );

    cfg_port_ctrl #(.OFF_W(OFF_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .rd(bus_rd), .size(bus_size),
        .wdata(bus_wdata), .is_sel(dec_sel), .is_data(dec_data),
        .item_len(item_len), .lanes(lanes), .sel_key(sel_key), .rd_off(rd_off),
        .rdata(bus_rdata), .rvalid(bus_rvalid), .busy(bus_busy)
    );
endmodule

// File: rtl/cfg_item_port_chk.sv
module cfg_item_port_chk #(
    parameter int OFF_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr,
    input logic             bus_rd,
    input logic [15:0]      bus_wdata,
    input logic [63:0]      bus_rdata,
    input logic             bus_rvalid,
    input logic             bus_busy,
    input logic             is_sel,
    input logic             is_data,
    input logic [15:0]      sel_key,
    input logic [OFF_W-1:0] rd_off,
    input logic [OFF_W-1:0] item_len
);
    AST_SEL_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_busy && bus_wr && is_sel) |=> (sel_key == $past(bus_wdata) && rd_off == '0)); // R2

    AST_OFF_WITHIN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        rd_off <= item_len); // R8

    AST_DATA_WRITE_NOOP: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_busy && bus_wr && is_data) |=> ($stable(sel_key) && $stable(rd_off))); // R10

    AST_NONDATA_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_busy && bus_rd && !bus_wr && !is_data) |=> ##1 (bus_rvalid && bus_rdata == '0)); // R11

    AST_REPLY_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_busy && bus_rd && !bus_wr) |=> (bus_busy && !bus_rvalid) ##1 bus_rvalid); // R12

    AST_RVALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |=> !bus_rvalid); // R12

    AST_BUSY_KEY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_busy |=> $stable(sel_key)); // R12
endmodule

bind cfg_item_port cfg_item_port_chk #(.OFF_W(OFF_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .bus_busy(bus_busy), .is_sel(dec_sel), .is_data(dec_data),
    .sel_key(sel_key), .rd_off(rd_off), .item_len(item_len)
);

// File: tb/cfg_item_port_bench.sv
module cfg_item_port_bench;
    localparam logic [7:0]  A_DATA = 8'd0;
    localparam logic [7:0]  A_SEL  = 8'd8;
    localparam logic [31:0] SIG    = "CFGS";

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0]  bus_size = '0;
    logic [15:0] bus_wdata = '0;
    logic [63:0] bus_rdata;
    logic        bus_rvalid, bus_busy;

    int n_checks = 0, n_fail = 0;
    bit finished = 1'b0;
    logic [15:0] m_key = '0;
    int          m_off = 0;

    always #5 clk = ~clk;

    cfg_item_port u_cfg_item_port (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .bus_busy(bus_busy)
    );

    function automatic int exp_len(logic [15:0] k);
        int i = int'(k[13:0]);
        if (!k[15]) begin
            if (i == 0 || i == 1) return 4;
            if (i >= 32 && i < 36) return 3 + 5 * (i - 32);
            return 0;
        end
        return (i < 2) ? 6 + 2 * i : 0;
    endfunction

    function automatic logic [7:0] exp_byte(logic [15:0] k, int p);
        int i = int'(k[13:0]);
        if (p >= exp_len(k)) return 8'h00;
        if (!k[15]) begin
            if (i == 0) return SIG[31 - 8*p -: 8];
            if (i == 1) return (p == 0) ? 8'h03 : 8'h00;
            return 8'(37 * (i - 32) + 11 * p + 5);
        end
        return 8'(19 * i + 7 * p) ^ 8'hA0;
    endfunction

    function automatic logic [63:0] exp_read(logic [15:0] k, int off, int n);
        logic [63:0] v = '0;
        for (int l = 0; l < n; l++) v[8*l +: 8] = exp_byte(k, off + l);
        return v;
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        if (a == A_SEL) begin m_key = d; m_off = 0; end
    endtask

    task automatic read_reg(input logic [7:0] a, input logic [1:0] sz, input string req);
        int n = 1 << sz;
        logic [63:0] e;
        @(negedge clk);
        bus_addr = a; bus_size = sz; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        check(bus_busy === 1'b1 && bus_rvalid === 1'b0, "R12", {62'b0, bus_busy, bus_rvalid}, 64'h2);
        @(negedge clk);
        check(bus_rvalid === 1'b1, "R12", {63'b0, bus_rvalid}, 64'h1);
        if (a == A_DATA) begin
            e = exp_read(m_key, m_off, n);
            m_off = (m_off + n > exp_len(m_key)) ? exp_len(m_key) : m_off + n;
        end else e = '0;
        check(bus_rdata === e, req, bus_rdata, e);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] keys [12] = '{16'h0000, 16'h0001, 16'h0020, 16'h0021, 16'h0022,
                                   16'h0023, 16'h4022, 16'h8000, 16'h8001, 16'hC001,
                                   16'h0030, 16'h8005};
        logic [63:0] a, b;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        // R1: reset state
        check(bus_busy === 1'b0 && bus_rvalid === 1'b0 && bus_rdata === '0, "R1",
              {bus_busy, bus_rvalid, bus_rdata[61:0]}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        read_reg(A_DATA, 2'd2, "R1 R4 signature");
        write_reg(A_SEL, 16'h0001);
        read_reg(A_DATA, 2'd2, "R5 feature");
        write_reg(A_SEL, 16'h0020);
        read_reg(A_DATA, 2'd3, "R3 R8 short item");
        read_reg(A_DATA, 2'd0, "R8 past end");
        write_reg(A_SEL, 16'h0022);
        read_reg(A_DATA, 2'd1, "R3 size2");
        read_reg(A_DATA, 2'd0, "R3 size1");
        read_reg(A_DATA, 2'd2, "R3 size4");
        read_reg(A_DATA, 2'd3, "R3 R8 saturate");
        write_reg(A_SEL, 16'h0022);
        read_reg(A_DATA, 2'd3, "R2 reselect");
        // R6: alias through bit 14
        write_reg(A_SEL, 16'h0021);
        @(negedge clk); bus_addr = A_DATA; bus_size = 2'd3; bus_rd = 1'b1;
        @(negedge clk); bus_rd = 1'b0; @(negedge clk); a = bus_rdata; @(negedge clk);
        write_reg(A_SEL, 16'h4021);
        @(negedge clk); bus_addr = A_DATA; bus_size = 2'd3; bus_rd = 1'b1;
        @(negedge clk); bus_rd = 1'b0; @(negedge clk); b = bus_rdata; @(negedge clk);
        check(a === b && a === exp_read(16'h0021, 0, 8), "R6", b, a);
        m_off = 8;
        write_reg(A_SEL, 16'h8001);
        read_reg(A_DATA, 2'd3, "R7 arch item");
        write_reg(A_SEL, 16'hC000);
        read_reg(A_DATA, 2'd3, "R7 R6 arch alias");
        write_reg(A_SEL, 16'h0030);
        read_reg(A_DATA, 2'd3, "R9 unknown generic");
        write_reg(A_SEL, 16'h8007);
        read_reg(A_DATA, 2'd3, "R9 unknown arch");
        // R10: data writes ignored
        write_reg(A_SEL, 16'h0023);
        read_reg(A_DATA, 2'd1, "R3");
        write_reg(A_DATA, 16'hFFFF);
        read_reg(A_DATA, 2'd1, "R10 continues after data write");
        // R11: read of selector address
        read_reg(A_SEL, 2'd3, "R11 selector read zero");
        read_reg(A_DATA, 2'd1, "R11 offset unmoved");
        // R12: selector write while busy is ignored
        @(negedge clk); bus_addr = A_DATA; bus_size = 2'd0; bus_rd = 1'b1;
        @(negedge clk); bus_rd = 1'b0;
        bus_addr = A_SEL; bus_wdata = 16'h0001; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
        a = exp_read(m_key, m_off, 1); m_off = m_off + 1;
        check(bus_rvalid === 1'b1 && bus_rdata === a, "R12 busy response", bus_rdata, a);
        @(negedge clk);
        read_reg(A_DATA, 2'd1, "R12 key kept");
        // random phase
        for (int it = 0; it < 400; it++) begin
            int c = int'($urandom_range(0, 9));
            if (c < 3) write_reg(A_SEL, keys[$urandom_range(0, 11)]);
            else if (c == 3) write_reg(A_DATA, 16'($urandom()));
            else if (c == 4) read_reg(A_SEL, 2'($urandom_range(0, 3)), "R11 random");
            else read_reg(A_DATA, 2'($urandom_range(0, 3)), "R3 R8 random");
        end
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule